// File: doc/BRIEF.md
# Iterative Floating-Point Divide and Square-Root Unit

This block computes either the quotient of two IEEE-754 single-precision numbers or the square root of one of them. It works one operation at a time. A single shared digit-recurrence datapath produces one result bit per clock for both operations, so each operation takes a fixed number of cycles. It sits beside a pipelined add/multiply unit and runs on its own. That unit keeps issuing while this one iterates, and the result is handed back the moment it is ready.

An operation starts when `start_i` is high while the unit is idle. The opcode and operands are captured on that edge. Both operands are first classified as zero, infinity, NaN or normal; denormal inputs count as zero. Special cases are settled from that classification. Normal operands go through the recurrence, and the raw result is then normalized, rounded to nearest-even and packed. The unit raises `done_o` for one cycle with the result on `result_o`. The result then stays there until the next operation completes.

Top module: `fpdsq_unit`

## Requirements
- R1: For normal operands with `op_sqrt_i`=0, `result_o` is `a_i`/`b_i` rounded to nearest, ties to even. Examples: 1/3 gives 0x3EAAAAAB, 1/7 gives 0x3E124925, 1/0x3F7FFFFF gives 0x3F800001.
- R2: `done_o` is high for exactly one cycle, 30 clock edges after the edge that accepted `start_i`. `busy_o` is high from the accepting edge until that done cycle, and is low in the done cycle.
- R3: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its timing, and no second `done_o` follows.
- R4: `result_o` holds its value in every cycle in which `done_o` is low, whatever the inputs do.
- R5: An operand whose exponent field is 0 counts as a signed zero. A finite result whose rounded biased exponent is 0 or lower comes out as a zero carrying the result's sign.
- R6: A finite quotient whose rounded biased exponent reaches 255 comes out as an infinity with the quotient's sign.
- R7: A NaN operand always produces the quiet NaN 0x7FC00000. For square root only `a_i` is examined.
- R8: Divide special cases. Nonzero finite divided by zero gives an infinity signed with the XOR of the operand signs. 0/0 and inf/inf give 0x7FC00000. Finite divided by infinity gives a zero signed with the XOR. Infinity divided by finite gives an infinity signed with the XOR.
- R9: Square root special cases. A negative nonzero operand, -infinity included, gives 0x7FC00000. -0 gives 0x80000000, +0 gives 0x00000000 and +infinity gives 0x7F800000.
- R10: For square root (`op_sqrt_i`=1) of a positive normal, the unbiased exponent is halved. When the exponent is odd the significand is doubled first. The root is then rounded to nearest-even. Examples: sqrt(2) gives 0x3FB504F3, sqrt(3) gives 0x3FDDB3D7, sqrt(0.25) gives 0x3F000000.
- R11: While `rst_n` is low, `busy_o` and `done_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation; taken only when idle |
| op_sqrt_i | input | 1 | 0 = divide a_i by b_i, 1 = square root of a_i |
| a_i | input | 32 | Dividend or radicand, IEEE-754 single |
| b_i | input | 32 | Divisor (ignored for square root) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | 32 | Result, held until the next completion |

## Verification
Every result, specials included, is due in the cycle after the 30th clock edge that follows the accepting edge. The bench counts edges from the accepting edge and reads `done_o`, `busy_o` and `result_o` one time unit after each edge. Each check is therefore a latency check as well as a value check. The hold and ignored-start checks read the outputs in the cycles between completions, and keep watching until well past the point where a restarted operation would have finished.

// File: rtl/fpdsq_pkg.sv
package fpdsq_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  // quotient/root bits: significand, guard, and one spare for the sub-one case
  localparam int QUO_W    = SIG_W + 2;
  localparam int RAD_W    = 2 * QUO_W;
  localparam int REM_W    = QUO_W + 4;
  localparam int EXPI_W   = EXP_W + 2;
  localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
    logic              is_zero;
    logic              is_inf;
    logic              is_nan;
  } fp_cls_t;
endpackage

// File: rtl/fpdsq_unpack.sv
module fpdsq_unpack
  import fpdsq_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fp_cls_t           cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_ones;

  assign exp_f    = word_i[WORD_W-2 -: EXP_W];
  assign frac_f   = word_i[FRAC_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (exp_f == '1);

  always_comb begin
    cls_o.sign    = word_i[WORD_W-1];
    cls_o.exp     = exp_f;
    cls_o.sig     = {1'b1, frac_f};
    cls_o.is_zero = exp_zero;              // denormals flushed
    cls_o.is_inf  = exp_ones && (frac_f == '0);
    cls_o.is_nan  = exp_ones && (frac_f != '0);
  end
endmodule

// File: rtl/fpdsq_special.sv
module fpdsq_special
  import fpdsq_pkg::*;
(
  input  logic              sqrt_i,
  input  fp_cls_t           a_i,
  input  fp_cls_t           b_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] val_o
);
  logic q_sign;
  assign q_sign = a_i.sign ^ b_i.sign;

  always_comb begin
    hit_o = 1'b1;
    val_o = '0;
    if (sqrt_i) begin
      if (a_i.is_nan)       val_o = QNAN_WORD;
      else if (a_i.is_zero) val_o = {a_i.sign, {(WORD_W-1){1'b0}}};
      else if (a_i.sign)    val_o = QNAN_WORD;
      else if (a_i.is_inf)  val_o = {1'b0, INF_MAG};
      else                  hit_o = 1'b0;
    end else begin
      if (a_i.is_nan || b_i.is_nan)
        val_o = QNAN_WORD;
      else if ((a_i.is_zero && b_i.is_zero) || (a_i.is_inf && b_i.is_inf))
        val_o = QNAN_WORD;
      else if (a_i.is_inf || b_i.is_zero)
        val_o = {q_sign, INF_MAG};
      else if (a_i.is_zero || b_i.is_inf)
        val_o = {q_sign, {(WORD_W-1){1'b0}}};
      else
        hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/fpdsq_engine.sv
module fpdsq_engine
  import fpdsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             sqrt_i,
  input  logic [SIG_W-1:0] num_i,
  input  logic [SIG_W-1:0] den_i,
  input  logic [RAD_W-1:0] rad_i,
  output logic [QUO_W-1:0] quo_o,
  output logic             sticky_o
);
  logic [REM_W-1:0] rem_q, rem_d;
  logic [QUO_W-1:0] quo_q, quo_d;
  logic [RAD_W-1:0] rad_q, rad_d;
  logic [SIG_W-1:0] den_q, den_d;
  logic             en;

  logic [REM_W-1:0] partial;
  logic [REM_W-1:0] trial;
  logic [REM_W:0]   diff;
  logic             qbit;
  logic [REM_W-1:0] kept;

  assign en = load_i | step_i;

  // one comparator/subtractor shared by both recurrences
  always_comb begin
    partial = sqrt_i ? {rem_q[REM_W-3:0], rad_q[RAD_W-1 -: 2]} : rem_q;
    trial   = sqrt_i ? REM_W'({quo_q, 2'b01}) : REM_W'(den_q);
    diff    = {1'b0, partial} - {1'b0, trial};
    qbit    = ~diff[REM_W];
    kept    = qbit ? diff[REM_W-1:0] : partial;
  end

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    rad_d = rad_q;
    den_d = den_q;
    if (load_i) begin
      rem_d = sqrt_i ? '0 : REM_W'(num_i);
      quo_d = '0;
      rad_d = rad_i;
      den_d = den_i;
    end else if (step_i) begin
      rem_d = sqrt_i ? kept : {kept[REM_W-2:0], 1'b0};
      quo_d = {quo_q[QUO_W-2:0], qbit};
      rad_d = {rad_q[RAD_W-3:0], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      rad_q <= '0;
      den_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      rad_q <= rad_d;
      den_q <= den_d;
    end
  end

  assign quo_o    = quo_q;
  assign sticky_o = |rem_q;
endmodule

// File: rtl/fpdsq_round.sv
module fpdsq_round
  import fpdsq_pkg::*;
(
  input  logic              sign_i,
  input  logic [EXPI_W-1:0] exp_i,
  input  logic [QUO_W-1:0]  quo_i,
  input  logic              sticky_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [EXPI_W-1:0] E_TOP = EXPI_W'((1 << EXP_W) - 1);

  logic              lead;
  logic [SIG_W-1:0]  mant_pre;
  logic              guard;
  logic              rest;
  logic              up;
  logic [SIG_W:0]    sum;
  logic              carry;
  logic [SIG_W-1:0]  mant_fin;
  logic [EXPI_W-1:0] e1, e2;
  logic              ovf, unf;

  always_comb begin
    lead     = quo_i[QUO_W-1];
    mant_pre = lead ? quo_i[QUO_W-1:2] : quo_i[QUO_W-2:1];
    guard    = lead ? quo_i[1] : quo_i[0];
    rest     = lead ? (quo_i[0] | sticky_i) : sticky_i;
    e1       = exp_i - {{(EXPI_W-1){1'b0}}, ~lead};
    up       = guard & (rest | mant_pre[0]);
    sum      = {1'b0, mant_pre} + {{SIG_W{1'b0}}, up};
    carry    = sum[SIG_W];
    mant_fin = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
    e2       = e1 + {{(EXPI_W-1){1'b0}}, carry};
    unf      = e2[EXPI_W-1] || (e2 == '0);
    ovf      = !e2[EXPI_W-1] && (e2 >= E_TOP);
    if (unf)      word_o = {sign_i, {(WORD_W-1){1'b0}}};
    else if (ovf) word_o = {sign_i, INF_MAG};
    else          word_o = {sign_i, e2[EXP_W-1:0], mant_fin[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpdsq_unit.sv
module fpdsq_unit
  import fpdsq_pkg::*;
#(
  parameter int LATENCY = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_sqrt_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o
);
  localparam int CNT_W      = $clog2(LATENCY + 1);
  localparam int STEP_FIRST = 2;
  localparam int STEP_LAST  = STEP_FIRST + QUO_W - 1;   // LATENCY must be >= this

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              op_q;
  logic [WORD_W-1:0] a_q, b_q;
  logic [WORD_W-1:0] res_q, res_d;

  logic accept, finish, load, step;

  fp_cls_t           cls [2];
  logic [WORD_W-1:0] opnd [2];
  logic              sp_hit;
  logic [WORD_W-1:0] sp_val;
  logic [RAD_W-1:0]  rad;
  logic [EXPI_W-1:0] exp_div, exp_sq, exp_sel;
  logic [QUO_W-1:0]  quo;
  logic              sticky;
  logic              rnd_sign;
  logic [WORD_W-1:0] rnd_word;

  // control
  assign accept = start_i & ~busy_q;
  assign finish = busy_q & (cnt_q == CNT_W'(LATENCY));
  assign load   = busy_q & (cnt_q == CNT_W'(1));
  assign step   = busy_q & (cnt_q >= CNT_W'(STEP_FIRST)) & (cnt_q <= CNT_W'(STEP_LAST));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (finish) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
    done_d = finish;
    res_d  = sp_hit ? sp_val : rnd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= op_sqrt_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (finish) res_q <= res_d;
  end

  // unpack both operands
  assign opnd[0] = a_q;
  assign opnd[1] = b_q;
  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpdsq_unpack u_unpack (.word_i(opnd[g]), .cls_o(cls[g]));
  end

  fpdsq_special u_special (
    .sqrt_i (op_q),
    .a_i    (cls[0]),
    .b_i    (cls[1]),
    .hit_o  (sp_hit),
    .val_o  (sp_val)
  );

  // odd unbiased exponent (even biased field) doubles the significand
  always_comb begin
    if (cls[0].exp[0]) rad = {1'b0, cls[0].sig, {(RAD_W-SIG_W-1){1'b0}}};
    else               rad = {cls[0].sig, {(RAD_W-SIG_W){1'b0}}};
    exp_div  = {2'b00, cls[0].exp} - {2'b00, cls[1].exp} + EXPI_W'(EXP_BIAS);
    exp_sq   = ({2'b00, cls[0].exp} + EXPI_W'(EXP_BIAS)) >> 1;
    exp_sel  = op_q ? exp_sq : exp_div;
    rnd_sign = op_q ? 1'b0 : (cls[0].sign ^ cls[1].sign);
  end

  fpdsq_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .sqrt_i   (op_q),
    .num_i    (cls[0].sig),
    .den_i    (cls[1].sig),
    .rad_i    (rad),
    .quo_o    (quo),
    .sticky_o (sticky)
  );

  fpdsq_round u_round (
    .sign_i   (rnd_sign),
    .exp_i    (exp_sel),
    .quo_i    (quo),
    .sticky_i (sticky),
    .word_o   (rnd_word)
  );

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/fpdsq_unit_chk.sv
module fpdsq_unit_chk
  import fpdsq_pkg::*;
#(
  parameter int LATENCY = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              op_sqrt_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] result_o
);
  localparam int CW = $clog2(LATENCY + 3);

  logic [CW-1:0]     age_q;
  logic              lat_sqrt;
  logic [WORD_W-1:0] lat_a, lat_b;
  logic              acc;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q    <= '0;
      lat_sqrt <= 1'b0;
      lat_a    <= '0;
      lat_b    <= '0;
    end else begin
      if (acc) begin
        age_q    <= CW'(1);
        lat_sqrt <= op_sqrt_i;
        lat_a    <= a_i;
        lat_b    <= b_i;
      end else if (age_q != '0 && age_q < CW'(LATENCY + 2)) begin
        age_q    <= age_q + CW'(1);
      end
    end
  end

  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (age_q == CW'(LATENCY + 1)));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (age_q >= CW'(1) && age_q <= CW'(LATENCY)));

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  p_nan_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ((lat_a[30:23] == 8'hFF && lat_a[22:0] != '0) ||
                (!lat_sqrt && lat_b[30:23] == 8'hFF && lat_b[22:0] != '0)))
    |-> (result_o == QNAN_WORD));

  p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !lat_sqrt && lat_b[30:23] == 8'h00 &&
     lat_a[30:23] != 8'h00 && lat_a[30:23] != 8'hFF)
    |-> (result_o == {lat_a[31] ^ lat_b[31], INF_MAG}));

  p_sqrt_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && lat_sqrt && lat_a[31] && lat_a[30:23] != 8'h00)
    |-> (result_o == QNAN_WORD));
endmodule

bind fpdsq_unit fpdsq_unit_chk #(.LATENCY(LATENCY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .op_sqrt_i(op_sqrt_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/fpdsq_unit_tb.sv
module fpdsq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 30;
  localparam int NV         = 31;

  // {req[3:0], op, a, b, expected}; op 1 = square root
  localparam logic [100:0] VECS [NV] = '{
    {4'd1,  1'b0, 32'h3F800000, 32'h40400000, 32'h3EAAAAAB},  // R1 1/3
    {4'd1,  1'b0, 32'h40C00000, 32'h40000000, 32'h40400000},  // R1 6/2
    {4'd1,  1'b0, 32'hBF800000, 32'h40800000, 32'hBE800000},  // R1 -1/4
    {4'd1,  1'b0, 32'h40000000, 32'h40400000, 32'h3F2AAAAB},  // R1 2/3
    {4'd1,  1'b0, 32'h3F800000, 32'h40E00000, 32'h3E124925},  // R1 1/7
    {4'd1,  1'b0, 32'h3F800000, 32'h3F7FFFFF, 32'h3F800001},  // R1 round up
    {4'd1,  1'b0, 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF},  // R1 max finite
    {4'd10, 1'b1, 32'h40800000, 32'h00000000, 32'h40000000},  // R10 sqrt 4
    {4'd10, 1'b1, 32'h40000000, 32'h00000000, 32'h3FB504F3},  // R10 sqrt 2
    {4'd10, 1'b1, 32'h41100000, 32'h00000000, 32'h40400000},  // R10 sqrt 9
    {4'd10, 1'b1, 32'h3E800000, 32'h00000000, 32'h3F000000},  // R10 sqrt .25
    {4'd10, 1'b1, 32'h40400000, 32'h00000000, 32'h3FDDB3D7},  // R10 sqrt 3
    {4'd10, 1'b1, 32'h3F7FFFFF, 32'h00000000, 32'h3F7FFFFF},  // R10 below 1
    {4'd6,  1'b0, 32'h7F000000, 32'h3E800000, 32'h7F800000},  // R6 overflow
    {4'd5,  1'b0, 32'h00800000, 32'h40000000, 32'h00000000},  // R5 underflow
    {4'd5,  1'b0, 32'h80000001, 32'h3F800000, 32'h80000000},  // R5 denormal in
    {4'd8,  1'b0, 32'h3F800000, 32'h00000001, 32'h7F800000},  // R8 by denormal
    {4'd8,  1'b0, 32'hBF800000, 32'h00000000, 32'hFF800000},  // R8 -1/0
    {4'd8,  1'b0, 32'h3F800000, 32'h80000000, 32'hFF800000},  // R8 1/-0
    {4'd8,  1'b0, 32'h00000000, 32'h00000000, 32'h7FC00000},  // R8 0/0
    {4'd8,  1'b0, 32'h7F800000, 32'hFF800000, 32'h7FC00000},  // R8 inf/inf
    {4'd8,  1'b0, 32'h3F800000, 32'h7F800000, 32'h00000000},  // R8 x/inf
    {4'd8,  1'b0, 32'hFF800000, 32'h40000000, 32'hFF800000},  // R8 inf/x
    {4'd7,  1'b0, 32'h7FC00000, 32'h3F800000, 32'h7FC00000},  // R7 nan a
    {4'd7,  1'b0, 32'h3F800000, 32'h7F800001, 32'h7FC00000},  // R7 nan b
    {4'd9,  1'b1, 32'hBF800000, 32'h00000000, 32'h7FC00000},  // R9 sqrt -1
    {4'd9,  1'b1, 32'h80000000, 32'h00000000, 32'h80000000},  // R9 sqrt -0
    {4'd9,  1'b1, 32'h7F800000, 32'h00000000, 32'h7F800000},  // R9 sqrt inf
    {4'd9,  1'b1, 32'hFF800000, 32'h00000000, 32'h7FC00000},  // R9 sqrt -inf
    {4'd7,  1'b1, 32'h7FC00001, 32'h00000000, 32'h7FC00000},  // R7 sqrt nan
    {4'd9,  1'b1, 32'h00000000, 32'h00000000, 32'h00000000}   // R9 sqrt +0
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        op_sqrt_i;
  logic [31:0] a_i, b_i;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks;
  int errors;

  fpdsq_unit #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sqrt_i(op_sqrt_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // start one operation; return result and edges from acceptance to done
  task automatic run_op(input logic op, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat);
    int n;
    @(negedge clk);
    start_i = 1'b1; op_sqrt_i = op; a_i = a; b_i = b;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1;
      start_i = 1'b0;
      n++;
      if (done_o) break;
    end
    lat = n - 1;
    res = result_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] res, held;
    int          lat;
    int          extra;
    checks = 0; errors = 0;
    rst_n = 1'b0; start_i = 1'b0; op_sqrt_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(posedge clk); #1;
    chk("R11 reset busy", {31'b0, busy_o}, 32'd0);
    chk("R11 reset done", {31'b0, done_o}, 32'd0);
    chk("R11 reset result", result_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i][96], VECS[i][95:64], VECS[i][63:32], res, lat);
      chk($sformatf("R%0d vec%0d result", VECS[i][100:97], i), res, VECS[i][31:0]);
      chk($sformatf("R2 vec%0d latency", i), lat, LAT);
    end

    // R2: pulse width and busy low in done cycle, busy high mid-run
    run_op(1'b0, 32'h40C00000, 32'h40000000, res, lat);
    chk("R2 busy low at done", {31'b0, busy_o}, 32'd0);
    @(posedge clk); #1;
    chk("R2 done one cycle", {31'b0, done_o}, 32'd0);

    // R3: start while busy is ignored
    @(negedge clk);
    start_i = 1'b1; op_sqrt_i = 1'b0; a_i = 32'h3F800000; b_i = 32'h40400000;
    @(posedge clk); #1; start_i = 1'b0;
    repeat (4) @(posedge clk); #1;
    chk("R2 busy mid-run", {31'b0, busy_o}, 32'd1);
    start_i = 1'b1; op_sqrt_i = 1'b1; a_i = 32'h40800000; b_i = 32'h0;
    @(posedge clk); #1; start_i = 1'b0;
    lat = 5;
    while (!done_o && lat < 100) begin
      @(posedge clk); #1; lat++;
    end
    chk("R3 latency unchanged", lat, LAT);
    chk("R3 first operands kept", result_o, 32'h3EAAAAAB);
    extra = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (done_o || busy_o) extra++;
    end
    chk("R3 no second operation", extra, 0);

    // R4: result holds while inputs move without a start
    held = result_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); a_i = 32'h12345678 + k; b_i = ~a_i; op_sqrt_i = k[0];
    end
    @(posedge clk); #1;
    chk("R4 result held", result_o, held);

    // R2: start in the done cycle is accepted
    run_op(1'b1, 32'h41100000, 32'h0, res, lat);
    @(negedge clk);
    start_i = 1'b1; op_sqrt_i = 1'b0; a_i = 32'h3F800000; b_i = 32'h40E00000;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); #1; start_i = 1'b0; lat++;
      if (done_o) break;
    end
    chk("R2 back-to-back latency", lat - 1, LAT);
    chk("R1 back-to-back result", result_o, 32'h3E124925);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule